// File: doc/BRIEF.md
# Fixed-Schedule Intersection Light Sequencer

The block drives the lamp heads of a two-road crossing on a fixed cycle of fifteen equal time slots. The north-south road has a main head (red, yellow, green) and a protected turn-arrow head (green arrow, yellow arrow, or dark). The east-west road has a main head only. An external one-cycle pulse marks each slot boundary. A slot counter steps through the schedule on each pulse and wraps after the last slot.

All lamp outputs come from registers. They are loaded from a decode of the counter's next value, so the lamps move to the new slot on the same clock edge that samples the pulse. Each 8-second slot gives a 120-second cycle. In that cycle the north-south red overlaps the whole 24-second arrow phase, so the red lamp and an arrow lamp are lit together.

Top module: `light_seq_top`

## Requirements
- R1: While rst_ni is low, and after its release until the first slot pulse, the outputs show slot 0: north-south red, green arrow and east-west red.
- R2: The lamps change only on a clock edge that samples slot_tick_i high. Without a pulse they hold their value.
- R3: After slot 14, the next pulse returns the schedule to slot 0.
- R4: The north-south main head shows red in slots 0 to 10, green in slots 11 to 13 and yellow in slot 14.
- R5: The arrow head shows the green arrow in slots 0 and 1, the yellow arrow in slot 2, and is dark in slots 3 to 14. An arrow is lit only while north-south red is lit.
- R6: The east-west head shows red in slots 0 to 2 and 11 to 14, green in slots 3 to 9 and yellow in slot 10.
- R7: Each main head has exactly one lamp lit at all times. Main heads use the encoding bit 0 red, bit 1 yellow, bit 2 green. The arrow head uses bit 0 yellow arrow, bit 1 green arrow, and 00 means dark.
- R8: Neither road's green is lit while the other road's green or yellow is lit.
- R9: The lamps for a new slot appear on the same clock edge that samples the pulse, with no further cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slot_tick_i | input | 1 | One-cycle pulse marking a slot boundary |
| ns_main_o | output | 3 | North-south main head, one-hot {green, yellow, red} |
| ns_arrow_o | output | 2 | North-south arrow head {green arrow, yellow arrow} |
| ew_main_o | output | 3 | East-west main head, one-hot {green, yellow, red} |

## Verification
Every result is due one edge after its stimulus. A pulse driven on a falling edge is sampled at the next rising edge, and the lamps for the new slot must be visible by the following falling edge. The bench drives all inputs at falling edges and samples all outputs at falling edges, so each check looks exactly one rising edge after the pulse. Between pulses, the idle gaps vary from zero to several cycles, and the bench samples at the end of each gap to confirm the lamps held. A reset in mid-cycle is checked the same way, one falling edge after it is asserted.

// File: rtl/light_seq_pkg.sv
package light_seq_pkg;
  localparam int unsigned NUM_SLOTS = 15;
  localparam int unsigned SLOT_W    = $clog2(NUM_SLOTS);

  // schedule boundaries (last slot of each phase)
  localparam int unsigned ARW_G_LAST = 1;
  localparam int unsigned ARW_Y_LAST = 2;
  localparam int unsigned EW_G_LAST  = 9;
  localparam int unsigned EW_Y_LAST  = 10;
  localparam int unsigned NS_G_LAST  = 13;

  // main head bit positions
  localparam int unsigned LMP_R = 0;
  localparam int unsigned LMP_Y = 1;
  localparam int unsigned LMP_G = 2;
  // arrow head bit positions
  localparam int unsigned ARW_Y = 0;
  localparam int unsigned ARW_G = 1;

  typedef struct packed {
    logic [2:0] ns_main;
    logic [1:0] ns_arrow;
    logic [2:0] ew_main;
  } lamps_t;
endpackage

// File: rtl/light_slot_counter.sv
module light_slot_counter
  import light_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic [SLOT_W-1:0] slot_next_o
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_SLOTS - 1);

  logic [SLOT_W-1:0] slot_q;

  always_comb begin
    slot_next_o = slot_q;
    if (tick_i) slot_next_o = (slot_q == LAST) ? '0 : slot_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slot_q <= '0;
    else         slot_q <= slot_next_o;
  end

  assign slot_o = slot_q;

  // R3
  slot_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && slot_q == LAST) |=> slot_q == '0);
  // R3
  slot_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_q < SLOT_W'(NUM_SLOTS));
endmodule

// File: rtl/light_slot_decode.sv
module light_slot_decode
  import light_seq_pkg::*;
(
  input  logic [SLOT_W-1:0] slot_i,
  output lamps_t            lamps_o
);
  always_comb begin
    lamps_o = '0;
    // north-south main head
    if (slot_i <= SLOT_W'(EW_Y_LAST))      lamps_o.ns_main[LMP_R] = 1'b1;
    else if (slot_i <= SLOT_W'(NS_G_LAST)) lamps_o.ns_main[LMP_G] = 1'b1;
    else                                   lamps_o.ns_main[LMP_Y] = 1'b1;
    // protected turn arrow
    if (slot_i <= SLOT_W'(ARW_G_LAST))      lamps_o.ns_arrow[ARW_G] = 1'b1;
    else if (slot_i <= SLOT_W'(ARW_Y_LAST)) lamps_o.ns_arrow[ARW_Y] = 1'b1;
    // east-west main head
    if (slot_i <= SLOT_W'(ARW_Y_LAST))      lamps_o.ew_main[LMP_R] = 1'b1;
    else if (slot_i <= SLOT_W'(EW_G_LAST))  lamps_o.ew_main[LMP_G] = 1'b1;
    else if (slot_i <= SLOT_W'(EW_Y_LAST))  lamps_o.ew_main[LMP_Y] = 1'b1;
    else                                   lamps_o.ew_main[LMP_R] = 1'b1;
  end
endmodule

// File: rtl/light_seq_top.sv
module light_seq_top
  import light_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       slot_tick_i,
  output logic [2:0] ns_main_o,
  output logic [1:0] ns_arrow_o,
  output logic [2:0] ew_main_o
);
  logic [SLOT_W-1:0] slot_cur, slot_nxt;
  lamps_t            lamps_d, lamps_rst, lamps_q;

  light_slot_counter u_counter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (slot_tick_i),
    .slot_o      (slot_cur),
    .slot_next_o (slot_nxt)
  );

  // lamps decoded from next slot so they land on the tick edge
  light_slot_decode u_decode (
    .slot_i  (slot_nxt),
    .lamps_o (lamps_d)
  );

  light_slot_decode u_decode_rst (
    .slot_i  ('0),
    .lamps_o (lamps_rst)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lamps_q <= lamps_rst;
    else         lamps_q <= lamps_d;
  end

  assign ns_main_o  = lamps_q.ns_main;
  assign ns_arrow_o = lamps_q.ns_arrow;
  assign ew_main_o  = lamps_q.ew_main;

  // R7
  ns_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(ns_main_o) == 1);
  // R7
  ew_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(ew_main_o) == 1);
  // R8
  no_green_conflict_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ns_main_o[LMP_G] && (ew_main_o[LMP_G] || ew_main_o[LMP_Y])) &&
    !(ew_main_o[LMP_G] && (ns_main_o[LMP_G] || ns_main_o[LMP_Y])));
  // R5
  arrow_under_red_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ns_arrow_o) && ((ns_arrow_o != '0) -> ns_main_o[LMP_R]));
  // R2
  hold_without_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_tick_i |=> $stable(lamps_q));
  // R9
  lamps_track_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_tick_i |=> slot_cur != $past(slot_cur));
endmodule

// File: tb/light_seq_top_tb.sv
module light_seq_top_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       slot_tick_i = 1'b0;
  logic [2:0] ns_main_o;
  logic [1:0] ns_arrow_o;
  logic [2:0] ew_main_o;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  light_seq_top u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .slot_tick_i (slot_tick_i),
    .ns_main_o   (ns_main_o),
    .ns_arrow_o  (ns_arrow_o),
    .ew_main_o   (ew_main_o)
  );

  function automatic logic [2:0] exp_ns(int s);
    if (s <= 10) return 3'b001;
    if (s <= 13) return 3'b100;
    return 3'b010;
  endfunction

  function automatic logic [1:0] exp_arw(int s);
    if (s <= 1) return 2'b10;
    if (s == 2) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [2:0] exp_ew(int s);
    if (s <= 2)  return 3'b001;
    if (s <= 9)  return 3'b100;
    if (s == 10) return 3'b010;
    return 3'b001;
  endfunction

  task automatic check_slot(int s, string req);
    tests++;
    if (ns_main_o !== exp_ns(s) || ns_arrow_o !== exp_arw(s) || ew_main_o !== exp_ew(s)) begin
      fails++;
      $display("FAIL %s slot %0d: got ns=%b arw=%b ew=%b exp ns=%b arw=%b ew=%b",
               req, s, ns_main_o, ns_arrow_o, ew_main_o, exp_ns(s), exp_arw(s), exp_ew(s));
    end
  endtask

  task automatic tick;
    slot_tick_i = 1'b1;
    @(negedge clk_i);
    slot_tick_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int slot = 0;
    @(negedge clk_i);
    check_slot(0, "R1 in reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check_slot(0, "R1 after release");

    // three full cycles with varied gaps; R4 R5 R6 R9 per tick, R2 after gap
    for (int n = 0; n < 45; n++) begin
      tick();
      slot = (slot + 1) % 15;
      check_slot(slot, slot == 0 ? "R3 wrap" : "R9 R4 R5 R6 on tick");
      for (int g = 0; g < (n % 4); g++) @(negedge clk_i);
      check_slot(slot, "R2 hold");
    end

    // back-to-back ticks
    for (int n = 0; n < 16; n++) begin
      tick();
      slot = (slot + 1) % 15;
      check_slot(slot, "R2 back-to-back");
    end

    // mid-cycle reset
    tick(); tick();
    slot = (slot + 2) % 15;
    check_slot(slot, "R4 before reset");
    rst_ni = 1'b0;
    @(negedge clk_i);
    check_slot(0, "R1 mid-cycle reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    tick();
    check_slot(1, "R1 restart");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule